// File: doc/BRIEF.md
# Copula Default Test and Loss Summer

This block works through one Monte-Carlo path of a one-factor Gaussian copula credit model. At the start of a path it captures the systemic factor. It then accepts a stream of asset records. Each record holds a weight, the precomputed complement of that weight, an idiosyncratic sample, a loss amount and a default-curve index. For each asset the block forms the latent value as weight times systemic factor plus complement times idiosyncratic sample. Every time-step lane compares that value against its own threshold from a preloaded table, which is indexed by curve and time step. A lane adds the asset's loss when the value falls below the threshold.

There is one lane per time step, and all lanes test the same asset in the same cycle. Each lane accumulates through an adder pipeline of depth P. Consecutive assets are spread round-robin over P partial sums, so an asset can arrive on every cycle without a stall. After the last asset of a path, the block drains the adder pipeline and merges each lane's partial sums. It then emits one pool loss per time step, in ascending step order, and flags the final one.

Top module: `copula_loss_summer`

## Requirements
- R1: With a, c, z, x taken as signed 16-bit integers, the full-precision sum s = a·x + c·z counts as a default at step k exactly when s < T·2^14, where T is the signed threshold for the asset's curve and step k. Equality is not a default.
- R2: A write strobe stores a 16-bit signed threshold at a given curve and step. Assets accepted after the write use the new value, and lane k uses the entry for step k.
- R3: The pool loss emitted for step k equals the sum of the loss amounts of all assets of the path that default at step k.
- R4: Each asset is tested against the thresholds of its own curve index only.
- R5: After the asset flagged last is accepted, busy is high from the next cycle until emission ends. Asset records and path starts presented while busy is high are ignored.
- R6: A path produces exactly LANES output beats in consecutive cycles, with step numbers 0, 1, … LANES−1 in that order.
- R7: The last-of-path flag is high on the step LANES−1 beat only, and no beat follows it.
- R8: A path start captures the systemic factor and clears all sums, so each path's losses are independent of earlier paths.
- R9: Assets arriving on every cycle, or with idle gaps between them, accumulate correctly for any number of assets, including more than P.
- R10: After reset, busy and the output valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_we | input | 1 | Threshold table write strobe |
| thr_curve | input | 2 | Curve index of the threshold write |
| thr_step | input | 3 | Time step of the threshold write |
| thr_value | input | 16 | Signed threshold value |
| path_start | input | 1 | Begin a path: capture the systemic factor and clear the sums |
| sys_x | input | 16 | Signed systemic factor |
| asset_valid | input | 1 | Asset record present |
| asset_last | input | 1 | Record is the final asset of the path |
| asset_a | input | 16 | Signed weight, 14 fraction bits |
| asset_ac | input | 16 | Signed complement weight, 14 fraction bits |
| asset_z | input | 16 | Signed idiosyncratic sample |
| asset_loss | input | 24 | Unsigned loss amount |
| asset_curve | input | 2 | Default-curve index |
| busy | output | 1 | Draining, merging or emitting |
| loss_valid | output | 1 | Pool loss beat valid |
| loss_step | output | 3 | Time step of the beat |
| loss_value | output | 32 | Pool loss for that step |
| loss_last | output | 1 | Final beat of the path |

## Verification
The bench uses the default build: eight time-step lanes, four curves and an adder depth of four. A twelve-asset path therefore reuses every partial-sum slot three times. Sending those assets back to back makes each slot's write-back meet the read of the next asset assigned to that slot. A single-asset path sits exactly on a threshold and then just below a rewritten one, which exercises the strict comparison and a table update. Asset records injected during the drain show whether ignored input leaks into a path already closed.

// File: rtl/copula_pkg.sv
package copula_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_MERGE = 2'd2,
    ST_EMIT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/copula_latent.sv
module copula_latent #(
  parameter int W  = 16,
  parameter int LW = 24,
  parameter int CW = 2,
  parameter int P  = 4,
  localparam int SLW  = $clog2(P),
  localparam int SUMW = 2 * W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic signed [W-1:0]    sys_x_i,
  input  logic                   take_i,
  input  logic signed [W-1:0]    a_i,
  input  logic signed [W-1:0]    ac_i,
  input  logic signed [W-1:0]    z_i,
  input  logic [LW-1:0]          loss_i,
  input  logic [CW-1:0]          curve_i,
  output logic                   s1_valid_o,
  output logic signed [SUMW-1:0] s1_sum_o,
  output logic [LW-1:0]          s1_loss_o,
  output logic [CW-1:0]          s1_curve_o,
  output logic [SLW-1:0]         s1_slot_o
);
  logic signed [W-1:0]    x_q, x_d;
  logic [SLW-1:0]         slot_q, slot_d;
  logic signed [2*W-1:0]  prod_ax, prod_cz;
  logic signed [SUMW-1:0] sum_d;

  // Full-precision latent value, no rounding before the compare
  always_comb begin
    prod_ax = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{x_q[W-1]}}, x_q});
    prod_cz = $signed({{W{ac_i[W-1]}}, ac_i}) * $signed({{W{z_i[W-1]}}, z_i});
    sum_d   = $signed({prod_ax[2*W-1], prod_ax}) + $signed({prod_cz[2*W-1], prod_cz});
    x_d     = clear_i ? sys_x_i : x_q;
    if (clear_i)     slot_d = '0;
    else if (take_i) slot_d = (slot_q == SLW'(P - 1)) ? '0 : slot_q + 1'b1;
    else             slot_d = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q        <= '0;
      slot_q     <= '0;
      s1_valid_o <= 1'b0;
      s1_sum_o   <= '0;
      s1_loss_o  <= '0;
      s1_curve_o <= '0;
      s1_slot_o  <= '0;
    end else begin
      x_q        <= x_d;
      slot_q     <= slot_d;
      s1_valid_o <= take_i;
      if (take_i) begin
        s1_sum_o   <= sum_d;
        s1_loss_o  <= loss_i;
        s1_curve_o <= curve_i;
        s1_slot_o  <= slot_q;
      end
    end
  end

  // R9: every accepted asset reaches the compare stage on the next cycle
  p_take_reaches_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> s1_valid_o);
endmodule

// File: rtl/copula_lane.sv
module copula_lane #(
  parameter int W    = 16,
  parameter int LW   = 24,
  parameter int ACCW = 32,
  parameter int P    = 4,
  parameter int FRAC = 14,
  localparam int SLW  = $clog2(P),
  localparam int SUMW = 2 * W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   in_valid_i,
  input  logic signed [SUMW-1:0] in_sum_i,
  input  logic [LW-1:0]          in_loss_i,
  input  logic [SLW-1:0]         in_slot_i,
  input  logic signed [W-1:0]    thr_i,
  input  logic                   merge_i,
  output logic [ACCW-1:0]        merged_o
);
  logic [ACCW-1:0]        part_q  [P];
  logic [ACCW-1:0]        part_d  [P];
  logic [P-2:0]           pv_q, pv_d;
  logic [SLW-1:0]         pslot_q [P-1];
  logic [SLW-1:0]         pslot_d [P-1];
  logic [ACCW-1:0]        pval_q  [P-1];
  logic [ACCW-1:0]        pval_d  [P-1];
  logic signed [SUMW-1:0] thr_scaled;
  logic                   hit;
  logic [ACCW-1:0]        addend, merge_sum;

  always_comb begin
    thr_scaled = $signed({{(SUMW-W){thr_i[W-1]}}, thr_i}) <<< FRAC;
    hit        = in_valid_i && (in_sum_i < thr_scaled);
    addend     = hit ? ACCW'(in_loss_i) : '0;

    // Adder pipeline: read-add in stage 0, write back after P-1 more stages,
    // one cycle before the same slot can be read again
    part_d     = part_q;
    pv_d[0]    = in_valid_i;
    pslot_d[0] = in_slot_i;
    pval_d[0]  = part_q[in_slot_i] + addend;
    for (int k = 1; k < P - 1; k++) begin
      pv_d[k]    = pv_q[k-1];
      pslot_d[k] = pslot_q[k-1];
      pval_d[k]  = pval_q[k-1];
    end
    if (pv_q[P-2]) part_d[pslot_q[P-2]] = pval_q[P-2];
    if (clear_i) begin
      for (int k = 0; k < P; k++) part_d[k] = '0;
      pv_d = '0;
    end

    merge_sum = '0;
    for (int k = 0; k < P; k++) merge_sum = merge_sum + part_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q     <= '0;
      merged_o <= '0;
      for (int k = 0; k < P; k++) part_q[k] <= '0;
      for (int k = 0; k < P - 1; k++) begin
        pslot_q[k] <= '0;
        pval_q[k]  <= '0;
      end
    end else begin
      pv_q <= pv_d;
      for (int k = 0; k < P; k++) part_q[k] <= part_d[k];
      for (int k = 0; k < P - 1; k++) begin
        pslot_q[k] <= pslot_d[k];
        pval_q[k]  <= pval_d[k];
      end
      if (merge_i) merged_o <= merge_sum;
    end
  end

  // R3: a partial sum changes only on a pipeline write-back or a path clear
  p_part_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pv_q[P-2] && !clear_i) |=> (part_q[0] == $past(part_q[0])));
  // R8: a path clear leaves partial sums empty
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (part_q[0] == '0 && pv_q == '0));
endmodule

// File: rtl/copula_seq.sv
module copula_seq
  import copula_pkg::*;
#(
  parameter int LANES = 8,
  parameter int P     = 4,
  localparam int STW = $clog2(LANES),
  localparam int DCW = $clog2(P + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_last_i,
  output logic           busy_o,
  output logic           merge_o,
  output logic           loss_valid_o,
  output logic [STW-1:0] loss_step_o,
  output logic           loss_last_o
);
  seq_state_e     state_q, state_d;
  logic [DCW-1:0] cnt_q, cnt_d;
  logic [STW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (take_last_i) begin
        state_d = ST_DRAIN;
        cnt_d   = '0;
      end
      ST_DRAIN: begin
        if (cnt_q == DCW'(P - 1)) state_d = ST_MERGE;
        else                      cnt_d   = cnt_q + 1'b1;
      end
      ST_MERGE: begin
        state_d = ST_EMIT;
        idx_d   = '0;
      end
      ST_EMIT: begin
        if (idx_q == STW'(LANES - 1)) state_d = ST_IDLE;
        else                          idx_d   = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign merge_o      = (state_q == ST_MERGE);
  assign loss_valid_o = (state_q == ST_EMIT);
  assign loss_step_o  = idx_q;
  assign loss_last_o  = (state_q == ST_EMIT) && (idx_q == STW'(LANES - 1));

  // R5: the block goes busy right after the final asset is accepted
  p_busy_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_last_i |=> busy_o);
  // R6: emission starts at step 0 and climbs by one each cycle
  p_first_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss_valid_o) |-> (loss_step_o == '0));
  p_step_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_valid_o && !loss_last_o) |=> (loss_valid_o && loss_step_o == $past(loss_step_o) + 1'b1));
  // R7: nothing follows the flagged final beat
  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loss_last_o |=> (!loss_valid_o && !busy_o));
endmodule

// File: rtl/copula_loss_summer.sv
module copula_loss_summer #(
  parameter int LANES  = 8,
  parameter int CURVES = 4,
  parameter int P      = 4,
  parameter int W      = 16,
  parameter int LW     = 24,
  parameter int ACCW   = 32,
  parameter int FRAC   = 14,
  localparam int CW   = $clog2(CURVES),
  localparam int STW  = $clog2(LANES),
  localparam int SLW  = $clog2(P),
  localparam int SUMW = 2 * W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                thr_we,
  input  logic [CW-1:0]       thr_curve,
  input  logic [STW-1:0]      thr_step,
  input  logic signed [W-1:0] thr_value,
  input  logic                path_start,
  input  logic signed [W-1:0] sys_x,
  input  logic                asset_valid,
  input  logic                asset_last,
  input  logic signed [W-1:0] asset_a,
  input  logic signed [W-1:0] asset_ac,
  input  logic signed [W-1:0] asset_z,
  input  logic [LW-1:0]       asset_loss,
  input  logic [CW-1:0]       asset_curve,
  output logic                busy,
  output logic                loss_valid,
  output logic [STW-1:0]      loss_step,
  output logic [ACCW-1:0]     loss_value,
  output logic                loss_last
);
  logic [1:0]             rst_sync_q;
  logic                   rst_n_s;
  logic                   take, take_last, clear;
  logic                   merge;
  logic                   s1_valid;
  logic signed [SUMW-1:0] s1_sum;
  logic [LW-1:0]          s1_loss;
  logic [CW-1:0]          s1_curve;
  logic [SLW-1:0]         s1_slot;
  logic signed [W-1:0]    thr_q [CURVES][LANES];
  logic [ACCW-1:0]        lane_loss [LANES];

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign take      = asset_valid && !busy;
  assign take_last = take && asset_last;
  assign clear     = path_start && !busy;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int c = 0; c < CURVES; c++)
        for (int k = 0; k < LANES; k++) thr_q[c][k] <= '0;
    end else if (thr_we) begin
      thr_q[thr_curve][thr_step] <= thr_value;
    end
  end

  copula_latent #(.W(W), .LW(LW), .CW(CW), .P(P)) u_latent (
    .clk(clk), .rst_n(rst_n_s), .clear_i(clear), .sys_x_i(sys_x),
    .take_i(take), .a_i(asset_a), .ac_i(asset_ac), .z_i(asset_z),
    .loss_i(asset_loss), .curve_i(asset_curve),
    .s1_valid_o(s1_valid), .s1_sum_o(s1_sum), .s1_loss_o(s1_loss),
    .s1_curve_o(s1_curve), .s1_slot_o(s1_slot)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    copula_lane #(.W(W), .LW(LW), .ACCW(ACCW), .P(P), .FRAC(FRAC)) u_lane (
      .clk(clk), .rst_n(rst_n_s), .clear_i(clear),
      .in_valid_i(s1_valid), .in_sum_i(s1_sum), .in_loss_i(s1_loss),
      .in_slot_i(s1_slot), .thr_i(thr_q[s1_curve][g]),
      .merge_i(merge), .merged_o(lane_loss[g])
    );
  end

  copula_seq #(.LANES(LANES), .P(P)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .take_last_i(take_last),
    .busy_o(busy), .merge_o(merge), .loss_valid_o(loss_valid),
    .loss_step_o(loss_step), .loss_last_o(loss_last)
  );

  assign loss_value = lane_loss[loss_step];

  // R5: a record offered while busy never reaches the lanes
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (asset_valid && busy) |=> !s1_valid);
  // R10: reset leaves the outputs quiet
  p_quiet_after_reset_r10: assert property (@(posedge clk)
    !rst_n_s |-> (!busy && !loss_valid));
endmodule

// File: tb/copula_loss_summer_tb.sv
module copula_loss_summer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8, CURVES = 4, P = 4, W = 16, LW = 24, ACCW = 32, FRAC = 14;
  localparam int NV = 12;
  localparam int VA  [NV] = '{16000, 8192, 0, 12000, 4000, 15000, 9000, 2000, 11000, 6000, 14000, 3000};
  localparam int VAC [NV] = '{3600, 14189, 16384, 10835, 15889, 6590, 13690, 16261, 11887, 15251, 8500, 16106};
  localparam int VZ  [NV] = '{-5000, 2000, -7000, -1000, 0, -6000, 4000, -3000, -2500, 1500, -4500, 6000};
  localparam int VL  [NV] = '{1000, 2500, 40000, 7000, 123, 65000, 300, 5555, 9000, 12, 777, 31000};
  localparam int VC  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 1, 0, 3, 2};

  logic clk, rst_n;
  logic thr_we; logic [1:0] thr_curve; logic [2:0] thr_step; logic signed [W-1:0] thr_value;
  logic path_start; logic signed [W-1:0] sys_x;
  logic asset_valid, asset_last;
  logic signed [W-1:0] asset_a, asset_ac, asset_z;
  logic [LW-1:0] asset_loss; logic [1:0] asset_curve;
  logic busy, loss_valid, loss_last; logic [2:0] loss_step; logic [ACCW-1:0] loss_value;

  int checks = 0, fails = 0;
  int thr_m [CURVES][LANES];
  int pa [16], pac [16], pz [16], pl [16], pc [16];
  int np;
  longint exp_loss [LANES];

  copula_loss_summer #(.LANES(LANES), .CURVES(CURVES), .P(P), .W(W), .LW(LW), .ACCW(ACCW), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_curve(thr_curve), .thr_step(thr_step),
    .thr_value(thr_value), .path_start(path_start), .sys_x(sys_x),
    .asset_valid(asset_valid), .asset_last(asset_last), .asset_a(asset_a), .asset_ac(asset_ac),
    .asset_z(asset_z), .asset_loss(asset_loss), .asset_curve(asset_curve),
    .busy(busy), .loss_valid(loss_valid), .loss_step(loss_step), .loss_value(loss_value),
    .loss_last(loss_last));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  // Expected pool losses from R1/R3/R4
  task automatic model(input int x);
    for (int k = 0; k < LANES; k++) exp_loss[k] = 0;
    for (int i = 0; i < np; i++) begin
      longint s = longint'(pa[i]) * x + longint'(pac[i]) * pz[i];
      for (int k = 0; k < LANES; k++)
        if (s < longint'(thr_m[pc[i]][k]) * (longint'(1) << FRAC)) exp_loss[k] += pl[i];
    end
  endtask

  task automatic write_thr(input int c, input int k, input int v);
    thr_m[c][k] = v;
    thr_we = 1'b1; thr_curve = 2'(c); thr_step = 3'(k); thr_value = W'(v);
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic run_path(input int x, input int gap, input bit inject, input string req);
    int got;
    model(x);
    path_start = 1'b1; sys_x = W'(x);
    @(negedge clk);
    path_start = 1'b0;
    for (int i = 0; i < np; i++) begin
      asset_valid = 1'b1; asset_last = (i == np - 1);
      asset_a = W'(pa[i]); asset_ac = W'(pac[i]); asset_z = W'(pz[i]);
      asset_loss = LW'(pl[i]); asset_curve = 2'(pc[i]);
      @(negedge clk);
      if (gap != 0 && i != np - 1) begin
        asset_valid = 1'b0;
        @(negedge clk);
      end
    end
    asset_valid = 1'b0; asset_last = 1'b0;
    chk(busy == 1'b1, "R5", "busy after last asset", busy, 1);
    if (inject) begin
      // Records that would default everywhere; R5 says they are dropped
      for (int j = 0; j < 3; j++) begin
        asset_valid = 1'b1; asset_last = (j == 2); asset_a = '0; asset_ac = W'(16384);
        asset_z = W'(-30000); asset_loss = LW'(99999); asset_curve = 2'd0;
        path_start = (j == 1);
        @(negedge clk);
      end
      asset_valid = 1'b0; asset_last = 1'b0; path_start = 1'b0;
    end
    got = 0;
    for (int cyc = 0; cyc < 60 && got < LANES; cyc++) begin
      @(negedge clk);
      if (loss_valid) begin
        chk(loss_step == 3'(got), "R6", "step order", loss_step, got);
        chk(loss_value == ACCW'(exp_loss[got]), req, $sformatf("pool loss step %0d", got), loss_value, exp_loss[got]);
        chk(loss_last == (got == LANES - 1), "R7", "last flag", loss_last, (got == LANES - 1));
        got++;
      end
    end
    chk(got == LANES, "R6", "beat count", got, LANES);
    @(negedge clk);
    chk(loss_valid == 1'b0 && busy == 1'b0, "R7", "quiet after last beat", loss_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; thr_we = 1'b0; thr_curve = '0; thr_step = '0; thr_value = '0;
    path_start = 1'b0; sys_x = '0; asset_valid = 1'b0; asset_last = 1'b0;
    asset_a = '0; asset_ac = '0; asset_z = '0; asset_loss = '0; asset_curve = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    chk(loss_valid == 1'b0, "R10", "valid in reset", loss_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && loss_valid == 1'b0, "R10", "idle after reset", busy, 0);

    // R2: table load, thresholds rise with step
    for (int c = 0; c < CURVES; c++)
      for (int k = 0; k < LANES; k++) write_thr(c, k, -6000 + 900 * k + 300 * c);

    // Vector table walk: back to back (R9, R1, R4, R3)
    np = NV;
    for (int i = 0; i < NV; i++) begin
      pa[i] = VA[i]; pac[i] = VAC[i]; pz[i] = VZ[i]; pl[i] = VL[i]; pc[i] = VC[i];
    end
    run_path(3000, 0, 1'b0, "R9");
    // Same assets, new factor, idle gaps: sums restart (R8)
    run_path(-4000, 1, 1'b0, "R8");
    // Large positive factor, curve choice matters (R4)
    run_path(7000, 0, 1'b0, "R4");
    // Short path with records injected while busy (R5)
    np = 3;
    run_path(0, 0, 1'b1, "R5");
    // Single asset sitting exactly on the step-3 threshold of curve 0 (R1)
    np = 1; pa[0] = 0; pac[0] = 16384; pz[0] = -3300; pl[0] = 4242; pc[0] = 0;
    run_path(1234, 0, 1'b0, "R1");
    // Raise that threshold by one: step 3 now defaults (R2)
    write_thr(0, 3, -3299);
    run_path(1234, 0, 1'b0, "R2");
    chk(exp_loss[3] == 4242, "R2", "model step 3 after rewrite", exp_loss[3], 4242);

    summary();
    $finish;
  end
endmodule